// File: doc/BRIEF.md
# Effective Address Generation Unit

This block works out where an instruction's operand lives for an 8-bit processor with a 16-bit, 64 KB address space. The sequencer hands it the address of the first byte of the instruction, an addressing-mode code, a flag that says a one-byte prefix precedes the opcode, an operand-size flag, both index registers, an index select and the branch condition already evaluated elsewhere. The unit fetches whatever address bytes follow the opcode over a byte-wide read port. It then reports the effective address, the whole instruction length, the next program-counter value and a one-cycle done strobe.

The instruction starts at `op_addr`. When `prebyte` is set, the prefix byte sits at `op_addr` and the opcode at `op_addr+1`. Operand bytes always begin right after the opcode, at `op_addr + 1 + prebyte`. All inputs are captured on the cycle `start` is accepted. Addition wraps modulo 65536 everywhere.

The read port is a valid/ready request channel plus a response strobe. The unit raises `rd_req_valid` and holds `rd_addr` steady until the memory accepts with `rd_req_ready`, so the memory can stall requests for any number of cycles. Only one request is ever outstanding. The memory answers with `rd_rsp_valid` and `rd_rsp_data` on any later cycle. The unit always takes a response while it is waiting for one and ignores any response that arrives at another time.

Top module: `ea_resolver`

## Requirements
- R1: Immediate (mode code 3'd0) issues no memory reads. It sets `ea` to `op_addr + 1 + prebyte` and `ea_valid` to 1. `inst_len` is 2+prebyte when `wide_op`=0 and 3+prebyte when `wide_op`=1.
- R2: Direct (mode code 3'd1) reads one byte at `op_addr + 1 + prebyte`. `ea` is that byte with a high byte of 0x00, so it always lies in 0x0000–0x00FF. `inst_len` is 2+prebyte.
- R3: Extended (mode code 3'd2) reads two bytes at consecutive addresses starting at `op_addr + 1 + prebyte`. The first byte read is the high address byte and the second is the low byte. `inst_len` is 3+prebyte.
- R4: Indexed (mode code 3'd3) reads one offset byte. `ea` is the selected index register (`idx_x` when `sel_y`=0, `idx_y` when `sel_y`=1) plus the zero-extended offset, modulo 65536. `inst_len` is 2+prebyte.
- R5: Inherent (mode code 3'd4), and the unused codes 3'd6 and 3'd7, issue no reads. They give `ea_valid`=0, `ea`=0x0000 and `inst_len` of 1+prebyte.
- R6: Relative (mode code 3'd5) reads one offset byte. `inst_len` is 2+prebyte. `ea` is the branch target: `op_addr + inst_len` plus the sign-extended offset, modulo 65536. `next_pc` is that target when `br_cond`=1 and `op_addr + inst_len` when `br_cond`=0.
- R7: For every mode other than a taken branch, `next_pc` equals `op_addr + inst_len` modulo 65536, and `inst_len` lies between 1 and 4.
- R8: While `rd_req_valid` is high and `rd_req_ready` is low, `rd_req_valid` stays high and `rd_addr` does not change on the next cycle. A `rd_rsp_valid` pulse while the unit is idle has no effect on the next result.
- R9: `start` is taken only while `busy` is 0. A `start` raised while `busy` is 1 is ignored and produces no extra `done`.
- R10: `done` is high for exactly one cycle per accepted start. `ea`, `ea_valid`, `inst_len` and `next_pc` change only in the cycle `done` is high and hold until the next `done`.
- R11: After reset `busy`, `done`, `ea_valid` and `rd_req_valid` are 0, and `ea`, `inst_len` and `next_pc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin resolving; taken only while idle |
| busy | output | 1 | A resolution is in progress |
| op_addr | input | 16 | Address of the first byte of the instruction |
| mode | input | 3 | Addressing-mode code (0 imm, 1 dir, 2 ext, 3 idx, 4 inh, 5 rel) |
| prebyte | input | 1 | A prefix byte precedes the opcode |
| wide_op | input | 1 | Immediate operand is two bytes |
| sel_y | input | 1 | Indexed mode uses `idx_y` instead of `idx_x` |
| idx_x | input | 16 | First index register |
| idx_y | input | 16 | Second index register |
| br_cond | input | 1 | Branch condition is true |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_addr | output | 16 | Read address |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 8 | Returned byte |
| done | output | 1 | One-cycle completion strobe |
| ea | output | 16 | Effective address |
| ea_valid | output | 1 | The mode produces an effective address |
| inst_len | output | 3 | Total instruction length in bytes |
| next_pc | output | 16 | Address of the next instruction to run |

## Verification
On every cycle the assertions check the request channel's hold-under-stall rule and that a request appears only while busy. They also check that done is a single-cycle pulse, that results change only with done, that a direct result stays in the zero page, that inherent modes never flag an address, and that lengths stay in range. The arithmetic of each mode can only be shown by the bench's scenarios. These cover the operand ordering of extended mode, the sign handling of branch offsets, wrap-around at the top of memory and the prefix stretching of each length. The same holds for a start dropped while busy and a stray response arriving while idle.

// File: rtl/ea_resolver_pkg.sv
package ea_resolver_pkg;
  localparam int ADDR_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int MAX_OPS  = 2;
  localparam int CNT_W    = $clog2(MAX_OPS + 1);
  localparam int LEN_W    = 3;

  localparam logic [2:0] AM_IMM = 3'd0;
  localparam logic [2:0] AM_DIR = 3'd1;
  localparam logic [2:0] AM_EXT = 3'd2;
  localparam logic [2:0] AM_IDX = 3'd3;
  localparam logic [2:0] AM_INH = 3'd4;
  localparam logic [2:0] AM_REL = 3'd5;
endpackage

// File: rtl/ea_len_decode.sv
module ea_len_decode
  import ea_resolver_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int LW = LEN_W
) (
  input  logic [2:0]    mode,
  input  logic          prebyte,
  input  logic          wide_op,
  output logic [CW-1:0] n_fetch,
  output logic [LW-1:0] len
);
  logic [CW-1:0] n_ops;

  always_comb begin
    n_ops   = '0;
    n_fetch = '0;
    case (mode)
      AM_IMM: begin
        n_ops   = wide_op ? CW'(2) : CW'(1);
        n_fetch = '0;
      end
      AM_DIR, AM_IDX, AM_REL: begin
        n_ops   = CW'(1);
        n_fetch = CW'(1);
      end
      AM_EXT: begin
        n_ops   = CW'(2);
        n_fetch = CW'(2);
      end
      default: begin
        n_ops   = '0;
        n_fetch = '0;
      end
    endcase
    len = LW'(1) + LW'(prebyte) + LW'(n_ops);
  end
endmodule

// File: rtl/ea_byte_fetch.sv
module ea_byte_fetch #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int NB = 2,
  parameter int CW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [AW-1:0]    base,
  input  logic [CW-1:0]    count,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_rsp_valid,
  input  logic [DW-1:0]    rd_rsp_data,
  output logic [NB*DW-1:0] bytes_o,
  output logic             fin
);
  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fst_e;

  fst_e          st;
  logic [AW-1:0] base_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= F_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        F_IDLE: begin
          if (go && count != '0) begin
            base_q <= base;
            cnt_q  <= count;
            idx_q  <= '0;
            st     <= F_REQ;
          end
        end
        F_REQ: begin
          if (rd_req_ready) st <= F_WAIT;
        end
        F_WAIT: begin
          if (rd_rsp_valid) begin
            if (idx_q == cnt_q - CW'(1)) begin
              fin <= 1'b1;
              st  <= F_IDLE;
            end else begin
              idx_q <= idx_q + CW'(1);
              st    <= F_REQ;
            end
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  assign rd_req_valid = (st == F_REQ);
  assign rd_addr      = base_q + {{(AW-CW){1'b0}}, idx_q};

  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [DW-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (st == F_WAIT && rd_rsp_valid && idx_q == CW'(g)) begin
        byte_q <= rd_rsp_data;
      end
    end
    assign bytes_o[g*DW +: DW] = byte_q;
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));
endmodule

// File: rtl/ea_compute.sv
module ea_compute
  import ea_resolver_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int NB = 2,
  parameter int LW = 3
) (
  input  logic [2:0]       mode,
  input  logic             prebyte,
  input  logic             br_cond,
  input  logic             sel_y,
  input  logic [AW-1:0]    op_addr,
  input  logic [AW-1:0]    idx_x,
  input  logic [AW-1:0]    idx_y,
  input  logic [LW-1:0]    len,
  input  logic [NB*DW-1:0] bytes_i,
  output logic [AW-1:0]    ea,
  output logic             ea_valid,
  output logic [AW-1:0]    next_pc
);
  localparam int HW = AW - DW;

  logic [DW-1:0] b_first;
  logic [DW-1:0] b_second;
  logic [AW-1:0] seq_pc;
  logic [AW-1:0] opnd_addr;
  logic [AW-1:0] off_zero;
  logic [AW-1:0] off_sign;
  logic [AW-1:0] idx_base;
  logic [AW-1:0] br_target;

  assign b_first   = bytes_i[0 +: DW];
  assign b_second  = bytes_i[DW +: DW];
  assign seq_pc    = op_addr + {{(AW-LW){1'b0}}, len};
  assign opnd_addr = op_addr + {{(AW-1){1'b0}}, 1'b1} + {{(AW-1){1'b0}}, prebyte};
  assign off_zero  = {{HW{1'b0}}, b_first};
  assign off_sign  = {{HW{b_first[DW-1]}}, b_first};
  assign idx_base  = sel_y ? idx_y : idx_x;
  assign br_target = seq_pc + off_sign;

  always_comb begin
    ea       = '0;
    ea_valid = 1'b1;
    next_pc  = seq_pc;
    case (mode)
      AM_IMM: ea = opnd_addr;
      AM_DIR: ea = off_zero;
      AM_EXT: ea = AW'({b_first, b_second});
      AM_IDX: ea = idx_base + off_zero;
      AM_REL: begin
        ea      = br_target;
        next_pc = br_cond ? br_target : seq_pc;
      end
      default: begin
        ea       = '0;
        ea_valid = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ea_resolver.sv
module ea_resolver
  import ea_resolver_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = BYTE_W,
  parameter int NB = MAX_OPS,
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  input  logic [AW-1:0] op_addr,
  input  logic [2:0]    mode,
  input  logic          prebyte,
  input  logic          wide_op,
  input  logic          sel_y,
  input  logic [AW-1:0] idx_x,
  input  logic [AW-1:0] idx_y,
  input  logic          br_cond,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_rsp_valid,
  input  logic [DW-1:0] rd_rsp_data,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          ea_valid,
  output logic [LW-1:0] inst_len,
  output logic [AW-1:0] next_pc
);
  localparam int CW = $clog2(NB + 1);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_CALC} st_e;

  st_e             st;
  logic [2:0]      mode_q;
  logic            pre_q, wide_q, sely_q, cond_q;
  logic [AW-1:0]   op_q, x_q, y_q;

  logic [2:0]      d_mode;
  logic            d_pre, d_wide;
  logic [CW-1:0]   n_fetch;
  logic [LW-1:0]   d_len;
  logic            idle, accept, go;
  logic [AW-1:0]   fetch_base;
  logic [NB*DW-1:0] op_bytes;
  logic            fetch_fin;
  logic [AW-1:0]   c_ea, c_next;
  logic            c_ea_valid;

  assign idle   = (st == S_IDLE);
  assign busy   = !idle;
  assign accept = idle && start;
  assign d_mode = idle ? mode    : mode_q;
  assign d_pre  = idle ? prebyte : pre_q;
  assign d_wide = idle ? wide_op : wide_q;
  assign go     = accept && (n_fetch != '0);
  assign fetch_base = op_addr + {{(AW-1){1'b0}}, 1'b1} + {{(AW-1){1'b0}}, prebyte};

  ea_len_decode #(.CW(CW), .LW(LW)) u_len (
    .mode    (d_mode),
    .prebyte (d_pre),
    .wide_op (d_wide),
    .n_fetch (n_fetch),
    .len     (d_len)
  );

  ea_byte_fetch #(.AW(AW), .DW(DW), .NB(NB), .CW(CW)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (go),
    .base         (fetch_base),
    .count        (n_fetch),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_addr      (rd_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .bytes_o      (op_bytes),
    .fin          (fetch_fin)
  );

  ea_compute #(.AW(AW), .DW(DW), .NB(NB), .LW(LW)) u_calc (
    .mode     (mode_q),
    .prebyte  (pre_q),
    .br_cond  (cond_q),
    .sel_y    (sely_q),
    .op_addr  (op_q),
    .idx_x    (x_q),
    .idx_y    (y_q),
    .len      (d_len),
    .bytes_i  (op_bytes),
    .ea       (c_ea),
    .ea_valid (c_ea_valid),
    .next_pc  (c_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mode_q   <= '0;
      pre_q    <= 1'b0;
      wide_q   <= 1'b0;
      sely_q   <= 1'b0;
      cond_q   <= 1'b0;
      op_q     <= '0;
      x_q      <= '0;
      y_q      <= '0;
      done     <= 1'b0;
      ea       <= '0;
      ea_valid <= 1'b0;
      inst_len <= '0;
      next_pc  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            mode_q <= mode;
            pre_q  <= prebyte;
            wide_q <= wide_op;
            sely_q <= sel_y;
            cond_q <= br_cond;
            op_q   <= op_addr;
            x_q    <= idx_x;
            y_q    <= idx_y;
            st     <= (n_fetch != '0) ? S_FETCH : S_CALC;
          end
        end
        S_FETCH: begin
          if (fetch_fin) st <= S_CALC;
        end
        S_CALC: begin
          ea       <= c_ea;
          ea_valid <= c_ea_valid;
          inst_len <= d_len;
          next_pc  <= c_next;
          done     <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> busy);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(ea) && $stable(next_pc) && $stable(inst_len) && $stable(ea_valid)));

  // R2
  dir_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == AM_DIR) |-> (ea[AW-1:DW] == '0));

  // R5
  inh_no_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (mode_q == AM_INH || mode_q > AM_REL)) |-> (!ea_valid && ea == '0));

  // R7
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (inst_len >= LW'(1) && inst_len <= LW'(4)));
endmodule

// File: tb/ea_resolver_tb.sv
`timescale 1ns/1ps
module ea_resolver_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy;
  logic [15:0] op_addr = '0;
  logic [2:0]  mode = '0;
  logic        prebyte = 1'b0, wide_op = 1'b0, sel_y = 1'b0, br_cond = 1'b0;
  logic [15:0] idx_x = '0, idx_y = '0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b1;
  logic [15:0] rd_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [7:0]  rd_rsp_data = '0;
  logic        done;
  logic [15:0] ea;
  logic        ea_valid;
  logic [2:0]  inst_len;
  logic [15:0] next_pc;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ea_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .op_addr(op_addr), .mode(mode), .prebyte(prebyte), .wide_op(wide_op),
    .sel_y(sel_y), .idx_x(idx_x), .idx_y(idx_y), .br_cond(br_cond),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .done(done), .ea(ea), .ea_valid(ea_valid), .inst_len(inst_len), .next_pc(next_pc)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // memory model with optional request back-pressure
  logic        bp_en = 1'b0;
  logic        inj = 1'b0;
  int          cyc = 0;
  int          n_reads = 0;
  int          n_done = 0;
  int          bp_viol = 0;
  logic [15:0] rd_log [16];
  logic        prev_stall = 1'b0;
  logic [15:0] prev_addr = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_rsp_valid <= 1'b0;
    if (rd_req_valid && rd_req_ready) begin
      rd_rsp_valid <= 1'b1;
      rd_rsp_data  <= memf(rd_addr);
      rd_log[n_reads % 16] <= rd_addr;
      n_reads <= n_reads + 1;
    end else if (inj) begin
      rd_rsp_valid <= 1'b1;
      rd_rsp_data  <= 8'hEE;
    end
    rd_req_ready <= bp_en ? ((cyc % 3) == 2) : 1'b1;
    if (rst_n && prev_stall && (!rd_req_valid || rd_addr != prev_addr)) bp_viol <= bp_viol + 1;
    prev_stall <= rd_req_valid && !rd_req_ready;
    prev_addr  <= rd_addr;
    if (rst_n && done) n_done <= n_done + 1;
  end

  typedef struct packed {
    logic [15:0] op;
    logic [2:0]  md;
    logic        pre;
    logic        wide;
    logic        sy;
    logic        cond;
    logic [15:0] x;
    logic [15:0] y;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{16'h1000, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R1 byte
    '{16'h2000, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R1 word, prefix
    '{16'h3010, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R2
    '{16'h00C0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R2 prefix
    '{16'h4444, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R3
    '{16'hFFFE, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R3 wrap
    '{16'h5000, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFF0, 16'h1111}, // R4 X wrap
    '{16'h6000, 3'd3, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h1234}, // R4 Y
    '{16'h7000, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R5
    '{16'hFFFF, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R5 wrap
    '{16'h00C0, 3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0000}, // R6 back
    '{16'h1000, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R6 not taken
    '{16'h2040, 3'd5, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0000}, // R6 forward
    '{16'h0500, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R5 unused code
    '{16'hFFFC, 3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0000}  // R6 wrap
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_of(input vec_t v, output logic [15:0] e_ea, output logic e_v,
                           output logic [2:0] e_len, output logic [15:0] e_nx, output int e_rd);
    logic [15:0] a1, seq;
    logic [7:0] b0, b1;
    a1 = v.op + 16'd1 + {15'd0, v.pre};
    b0 = memf(a1);
    b1 = memf(a1 + 16'd1);
    e_v = 1'b1;
    e_rd = 1;
    case (v.md)
      3'd0: begin e_len = v.wide ? 3'd3 : 3'd2; e_ea = a1; e_rd = 0; end
      3'd1: begin e_len = 3'd2; e_ea = {8'h00, b0}; end
      3'd2: begin e_len = 3'd3; e_ea = {b0, b1}; e_rd = 2; end
      3'd3: begin e_len = 3'd2; e_ea = (v.sy ? v.y : v.x) + {8'h00, b0}; end
      3'd5: begin e_len = 3'd2; e_ea = 16'h0; end
      default: begin e_len = 3'd1; e_ea = 16'h0; e_v = 1'b0; e_rd = 0; end
    endcase
    e_len = e_len + {2'b0, v.pre};
    seq = v.op + {13'd0, e_len};
    e_nx = seq;
    if (v.md == 3'd5) begin
      e_ea = seq + {{8{b0[7]}}, b0};
      if (v.cond) e_nx = e_ea;
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    op_addr = v.op; mode = v.md; prebyte = v.pre; wide_op = v.wide;
    sel_y = v.sy; br_cond = v.cond; idx_x = v.x; idx_y = v.y;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t;
    t = 0;
    while (!done && t < 60) begin
      @(negedge clk);
      t++;
    end
    check(req, {31'd0, done}, 32'd1);
  endtask

  task automatic run_vec(input vec_t v, input string req);
    logic [15:0] e_ea, e_nx;
    logic e_v;
    logic [2:0] e_len;
    int e_rd, r0;
    expect_of(v, e_ea, e_v, e_len, e_nx, e_rd);
    r0 = n_reads;
    drive(v);
    wait_done(req);
    check({req, " ea"}, {16'd0, ea}, {16'd0, e_ea});
    check({req, " ea_valid"}, {31'd0, ea_valid}, {31'd0, e_v});
    check({req, " len"}, {29'd0, inst_len}, {29'd0, e_len});
    check({req, " next_pc"}, {16'd0, next_pc}, {16'd0, e_nx});
    check({req, " reads"}, n_reads - r0, e_rd);
    if (e_rd > 0)
      check({req, " first read addr"}, {16'd0, rd_log[r0 % 16]},
            {16'd0, v.op + 16'd1 + {15'd0, v.pre}});
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    vec_t v;
    int d0;
    logic [15:0] hold_ea, hold_nx;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 busy", {31'd0, busy}, 32'd0);
    check("R11 done", {31'd0, done}, 32'd0);
    check("R11 ea", {16'd0, ea}, 32'd0);
    check("R11 len", {29'd0, inst_len}, 32'd0);
    check("R11 next_pc", {16'd0, next_pc}, 32'd0);
    check("R11 rd_req_valid", {31'd0, rd_req_valid}, 32'd0);
    check("R11 ea_valid", {31'd0, ea_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk, back-pressure on odd entries; R7 length/next_pc in each
    for (int i = 0; i < NV; i++) begin
      bp_en = (i % 2) == 1;
      run_vec(VT[i], $sformatf("R1-6/R7 vec%0d", i));
    end
    bp_en = 1'b0;

    // R10: single-cycle done and held outputs
    run_vec(VT[4], "R3 again");
    hold_ea = ea;
    hold_nx = next_pc;
    @(negedge clk);
    check("R10 done width", {31'd0, done}, 32'd0);
    repeat (5) @(negedge clk);
    check("R10 ea held", {16'd0, ea}, {16'd0, hold_ea});
    check("R10 next_pc held", {16'd0, next_pc}, {16'd0, hold_nx});

    // R9: start while busy ignored
    bp_en = 1'b1;
    d0 = n_done;
    v = VT[5];
    drive(v);
    op_addr = 16'h9999; mode = 3'd4; start = 1'b1;
    check("R9 busy during fetch", {31'd0, busy}, 32'd1);
    @(negedge clk);
    start = 1'b0;
    wait_done("R9 done");
    begin
      logic [15:0] e_ea, e_nx; logic e_v; logic [2:0] e_len; int e_rd;
      expect_of(v, e_ea, e_v, e_len, e_nx, e_rd);
      check("R9 ea of first start", {16'd0, ea}, {16'd0, e_ea});
      check("R9 len of first start", {29'd0, inst_len}, {29'd0, e_len});
    end
    repeat (8) @(negedge clk);
    check("R9 single done", n_done - d0, 1);
    bp_en = 1'b0;

    // R8: stray response while idle has no effect
    inj = 1'b1;
    @(negedge clk);
    inj = 1'b0;
    repeat (2) @(negedge clk);
    run_vec(VT[2], "R8 stray rsp then R2");
    check("R8 request held under stall", bp_viol, 0);

    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule